// File: doc/BRIEF.md
# PS/2 Keyboard Receiver with Interrupt Request

This block takes the clock and data lines driven by a PS/2 keyboard, resynchronises them to the system clock and assembles each 11-bit frame into one 8-bit key code. When a frame completes with a valid start and stop bit, the code is stored in a holding register. A pending flag is then raised, and that flag drives the interrupt request output. The CPU reads the holding register at one address, which also drops the request. A second address returns status: whether a code is pending, and whether a code was overwritten before it was read. A handler on a shared interrupt line can therefore test the status without side effects.

A retriggerable timeout watches the PS/2 clock. Any edge of it restarts the count. If the count expires in the middle of a frame, the bits gathered so far are thrown away and the receiver waits for a new start bit. The parity bit is clocked in but not checked.

The frame engine has four states. `ST_IDLE` waits for a start bit. `ST_DATA` shifts in the data bits. `ST_PARITY` consumes the parity bit. `ST_STOP` checks the stop bit. The transitions are:
- IDLE->DATA on a falling edge with data low.
- IDLE->IDLE on a falling edge with data high (bad start).
- DATA->DATA on each of the first seven data bits.
- DATA->PARITY after the eighth data bit.
- PARITY->STOP on the next falling edge.
- STOP->IDLE on the next falling edge. The frame is delivered if data is high and dropped otherwise.
- Any state other than IDLE->IDLE when the timeout expires.

Top module: `kbd_rx_top`

## Requirements
- R1: Bits are sampled on falling edges of the PS/2 clock. After a start bit, the next 8 falling edges give data bits with the least significant bit first, and only those 8 bits are stored as the key code.
- R2: A frame whose start bit is low and whose stop bit is high sets the pending flag. `irq_o` follows the pending flag and is high within 8 system clocks of the stop-bit falling edge.
- R3: A read with `rd_en_i` high and `addr_i` = 0 returns the key code on `rdata_o`. On that clock it clears the pending flag (so `irq_o` falls) and clears the overrun flag.
- R4: A read with `addr_i` = 1 returns status: bit 0 is pending, bit 1 is overrun, bits 7:2 are zero. A status read changes no state.
- R5: The parity bit is not checked. A frame with either parity value is accepted.
- R6: A frame whose start bit is high or whose stop bit is low is dropped. No interrupt is raised and the stored code is unchanged.
- R7: If TIMEOUT_CYC system clocks pass with no PS/2 clock edge while a frame is in progress, the partial frame is discarded. A following complete frame is received correctly.
- R8: If a frame completes while a code is still pending, the new code replaces the old one and the overrun flag is set.
- R9: After reset, `irq_o` is low, the status reads 0 and the key code reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ps2_clk_i | input | 1 | Clock line from the keyboard (asynchronous) |
| ps2_dat_i | input | 1 | Data line from the keyboard (asynchronous) |
| rd_en_i | input | 1 | Valid read cycle strobe, high for one clock per access |
| addr_i | input | 1 | 0 selects the key code, 1 selects status |
| rdata_o | output | 8 | Read data for the selected location |
| irq_o | output | 1 | Interrupt request, high while a code is pending |

## Verification
The bench drives frames with a wrong parity bit and expects them to be accepted; a receiver that checked parity would miss them. It sends frames with a high start bit and with a low stop bit and expects no interrupt and an unchanged code; a receiver that skipped these checks would deliver a garbage code. It abandons a frame after four bits, waits past the timeout, and then sends a full frame. A receiver without the timeout would merge the two and store the wrong byte. It also sends two frames with no read between them. The second code must be stored with overrun set, and a status read must not drop the interrupt, which it would if status reads had side effects.

// File: rtl/kbd_rx_pkg.sv
package kbd_rx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DATA   = 2'd1,
        ST_PARITY = 2'd2,
        ST_STOP   = 2'd3
    } rx_state_e;

    localparam logic ADDR_CODE = 1'b0;
    localparam logic ADDR_STAT = 1'b1;
    localparam int   STAT_PEND_BIT = 0;
    localparam int   STAT_OVR_BIT  = 1;
endpackage

// File: rtl/kbd_line_sync.sv
module kbd_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ps2_clk_i,
    input  logic ps2_dat_i,
    output logic dat_o,
    output logic fall_o,
    output logic edge_o
);
    logic [STAGES-1:0] clk_sh;
    logic [STAGES-1:0] dat_sh;
    logic              clk_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_sh   <= '1;
            dat_sh   <= '1;
            clk_prev <= 1'b1;
        end else begin
            clk_sh   <= {clk_sh[STAGES-2:0], ps2_clk_i};
            dat_sh   <= {dat_sh[STAGES-2:0], ps2_dat_i};
            clk_prev <= clk_sh[STAGES-1];
        end
    end

    assign dat_o  = dat_sh[STAGES-1];
    assign fall_o = clk_prev & ~clk_sh[STAGES-1];
    assign edge_o = clk_prev ^ clk_sh[STAGES-1];

    // R1: a falling edge is only reported when the synchronised line was high one cycle earlier
    a_r1_fall_from_high: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |-> $past(clk_sh[STAGES-1]));
endmodule

// File: rtl/kbd_frame_fsm.sv
module kbd_frame_fsm
    import kbd_rx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int TIMEOUT_CYC = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dat_i,
    input  logic              fall_i,
    input  logic              edge_i,
    output logic              done_o,
    output logic [DATA_W-1:0] byte_o
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);
    localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT_CYC - 1);

    rx_state_e         state, state_nx;
    logic [CNT_W-1:0]  bitcnt;
    logic [DATA_W-1:0] shreg;
    logic [TMR_W-1:0]  tmr;
    logic              expire;

    assign expire = (state != ST_IDLE) && (tmr == TMR_LAST);

    // retriggerable timeout: any PS/2 clock edge restarts it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tmr <= '0;
        else if (state == ST_IDLE || edge_i)
            tmr <= '0;
        else if (!expire)
            tmr <= tmr + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (expire) begin
            state_nx = ST_IDLE;
        end else if (fall_i) begin
            unique case (state)
                ST_IDLE:   state_nx = dat_i ? ST_IDLE : ST_DATA;
                ST_DATA:   state_nx = (bitcnt == CNT_LAST) ? ST_PARITY : ST_DATA;
                ST_PARITY: state_nx = ST_STOP;
                ST_STOP:   state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt <= '0;
            shreg  <= '0;
            done_o <= 1'b0;
            byte_o <= '0;
        end else begin
            done_o <= 1'b0;
            if (fall_i && !expire) begin
                unique case (state)
                    ST_IDLE:   bitcnt <= '0;
                    ST_DATA: begin
                        shreg  <= {dat_i, shreg[DATA_W-1:1]};
                        bitcnt <= bitcnt + 1'b1;
                    end
                    ST_PARITY: ;
                    ST_STOP: begin
                        if (dat_i) begin
                            done_o <= 1'b1;
                            byte_o <= shreg;
                        end
                    end
                endcase
            end
        end
    end

    // R6: delivery only follows a stop-bit state
    a_r6_done_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(state == ST_STOP));
    // R7: an expired timeout always returns the engine to idle
    a_r7_timeout_idles: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (state == ST_IDLE));
    // R1: data bits are only collected in the data state
    a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PARITY) |-> (bitcnt == '0 || bitcnt == CNT_W'(DATA_W)));
endmodule

// File: rtl/kbd_hold_reg.sv
module kbd_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic              rd_code_i,
    output logic [DATA_W-1:0] code_o,
    output logic              pend_o,
    output logic              ovr_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_o <= '0;
            pend_o <= 1'b0;
            ovr_o  <= 1'b0;
        end else begin
            if (done_i) begin
                code_o <= byte_i;
                pend_o <= 1'b1;
                ovr_o  <= pend_o && !rd_code_i;
            end else if (rd_code_i) begin
                pend_o <= 1'b0;
                ovr_o  <= 1'b0;
            end
        end
    end

    // R2: a delivered frame makes the request pending
    a_r2_done_sets_pend: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> pend_o);
    // R3: a code read with no new frame releases the request
    a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_code_i && !done_i) |=> (!pend_o && !ovr_o));
    // R8: a frame landing on an unread code flags overrun
    a_r8_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && pend_o && !rd_code_i) |=> ovr_o);
    // R8: overrun never stands without a pending code
    a_r8_ovr_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_o |-> pend_o);
endmodule

// File: rtl/kbd_rx_top.sv
module kbd_rx_top
    import kbd_rx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int TIMEOUT_CYC = 100,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ps2_clk_i,
    input  logic              ps2_dat_i,
    input  logic              rd_en_i,
    input  logic              addr_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);
    logic              dat_s, fall_s, edge_s;
    logic              done;
    logic [DATA_W-1:0] rx_byte;
    logic [DATA_W-1:0] code;
    logic              pend, ovr;
    logic              rd_code;

    kbd_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .ps2_clk_i(ps2_clk_i), .ps2_dat_i(ps2_dat_i),
        .dat_o(dat_s), .fall_o(fall_s), .edge_o(edge_s)
    );

    kbd_frame_fsm #(.DATA_W(DATA_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .dat_i(dat_s), .fall_i(fall_s), .edge_i(edge_s),
        .done_o(done), .byte_o(rx_byte)
    );

    assign rd_code = rd_en_i && (addr_i == ADDR_CODE);

    kbd_hold_reg #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n),
        .done_i(done), .byte_i(rx_byte), .rd_code_i(rd_code),
        .code_o(code), .pend_o(pend), .ovr_o(ovr)
    );

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_STAT) begin
            rdata_o[STAT_PEND_BIT] = pend;
            rdata_o[STAT_OVR_BIT]  = ovr;
        end else begin
            rdata_o = code;
        end
    end

    assign irq_o = pend;

    // R4: a status read leaves the pending flag untouched
    a_r4_stat_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == ADDR_STAT && !done) |=> $stable(irq_o));
endmodule

// File: tb/tb_kbd_rx_top.sv
`timescale 1ns/1ps
module tb_kbd_rx_top;
    localparam int TO  = 100;
    localparam int HP  = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ps2_clk = 1'b1;
    logic       ps2_dat = 1'b1;
    logic       rd_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    kbd_rx_top #(.DATA_W(8), .TIMEOUT_CYC(TO), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .ps2_clk_i(ps2_clk), .ps2_dat_i(ps2_dat),
        .rd_en_i(rd_en), .addr_i(addr), .rdata_o(rdata), .irq_o(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ps2_bit(input logic b);
        ps2_dat = b;
        wait_clk(HP);
        ps2_clk = 1'b0;
        wait_clk(HP);
        ps2_clk = 1'b1;
    endtask

    // nbits: how many of the 11 bits to send
    task automatic send_frame(input logic [7:0] d, input logic start, input logic bad_par,
                              input logic stop, input int nbits);
        logic [10:0] f;
        f = {stop, (~^d) ^ bad_par, d, start};
        for (int i = 0; i < nbits; i++) ps2_bit(f[i]);
        ps2_dat = 1'b1;
        wait_clk(8);
    endtask

    task automatic cpu_read(input logic a, output logic [7:0] v);
        @(negedge clk);
        addr = a;
        rd_en = 1'b1;
        #0.5 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
        addr = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        check("R9 irq", {7'b0, irq}, 8'h00);
        cpu_read(1'b1, v); check("R9 status", v, 8'h00);
        cpu_read(1'b0, v); check("R9 code", v, 8'h00);
    endtask

    task automatic t_basic(input logic [7:0] d);
        logic [7:0] v;
        send_frame(d, 1'b0, 1'b0, 1'b1, 11);
        check("R2 irq after frame", {7'b0, irq}, 8'h01);
        cpu_read(1'b1, v); check("R4 status pending", v, 8'h01);
        check("R4 irq kept after status read", {7'b0, irq}, 8'h01);
        cpu_read(1'b0, v); check("R1 code value", v, d);
        check("R3 irq cleared by read", {7'b0, irq}, 8'h00);
        cpu_read(1'b1, v); check("R3 status cleared", v, 8'h00);
    endtask

    task automatic t_parity;
        logic [7:0] v;
        send_frame(8'h3C, 1'b0, 1'b1, 1'b1, 11);
        check("R5 bad parity accepted irq", {7'b0, irq}, 8'h01);
        cpu_read(1'b0, v); check("R5 bad parity code", v, 8'h3C);
    endtask

    task automatic t_bad_framing;
        logic [7:0] v;
        send_frame(8'h00, 1'b1, 1'b0, 1'b1, 11);
        wait_clk(TO + 40);
        check("R6 bad start no irq", {7'b0, irq}, 8'h00);
        send_frame(8'h77, 1'b0, 1'b0, 1'b0, 11);
        wait_clk(TO + 40);
        check("R6 bad stop no irq", {7'b0, irq}, 8'h00);
        cpu_read(1'b0, v); check("R6 code unchanged", v, 8'h3C);
    endtask

    task automatic t_timeout;
        logic [7:0] v;
        send_frame(8'h00, 1'b0, 1'b0, 1'b1, 4);
        wait_clk(TO + 40);
        check("R7 partial frame no irq", {7'b0, irq}, 8'h00);
        send_frame(8'h5A, 1'b0, 1'b0, 1'b1, 11);
        check("R7 irq after resync", {7'b0, irq}, 8'h01);
        cpu_read(1'b0, v); check("R7 code after resync", v, 8'h5A);
    endtask

    task automatic t_overrun;
        logic [7:0] v;
        send_frame(8'h11, 1'b0, 1'b0, 1'b1, 11);
        send_frame(8'hE2, 1'b0, 1'b0, 1'b1, 11);
        cpu_read(1'b1, v); check("R8 status overrun", v, 8'h03);
        cpu_read(1'b0, v); check("R8 newest code kept", v, 8'hE2);
        cpu_read(1'b1, v); check("R3 overrun cleared", v, 8'h00);
    endtask

    initial begin
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);
        t_reset();
        t_basic(8'hA5);
        t_basic(8'h01);
        t_basic(8'h80);
        t_parity();
        t_bad_framing();
        t_timeout();
        t_overrun();
        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule